// File: doc/BRIEF.md
# Microcoded Control Sequencer for a One-Bus Datapath

This block produces, every cycle, the control strobes for a datapath in which all registers share one internal bus: 32 general registers plus the program counter, instruction register, memory address and data registers, an ALU input latch (A) and an ALU result latch (C). The strobes do not come from hardwired decode. A micro-program counter selects a word from an internal control store, and the fields of that word drive the datapath strobes.

The control store holds two routines. The first is a three-step instruction fetch. The second is a three-step register-to-register add. At the end of fetch, an address generator takes the opcode of the incoming instruction and jumps to the routine for that opcode. When a word has its end marker set, control returns to fetch. An opcode that has no routine sends the sequencer to a halt word. The halt word raises an illegal-opcode flag, and the sequencer stays there until reset.

General registers are not selected by one strobe per register. Each word holds a vertical selector that names an instruction field (first source, second source or destination), an enable and a direction bit. The block turns this selector into a 5-bit register number taken from the matching field. Any step that requests a memory read stays in place until memory signals ready.

Top module: `useq_ctrl`

## Requirements
- R1: After reset the first fetch step is active. It asserts pc_bout_o, pc_out_o, mem_rd_o and c_in_o, with alu_fn_o = 2'b10 (add four). All other strobes and illegal_o are low and gpr_idx_o is 0.
- R2: A step that asserts mem_rd_o while mem_ready_i is low repeats on the next cycle with identical outputs. It advances one cycle after mem_ready_i is high.
- R3: The second fetch step asserts mem_rd_o, c_out_o and pc_in_o, with alu_fn_o = 2'b00 (none) and every other strobe low.
- R4: The third fetch step asserts mem_rd_o and ir_bin_o only. In that step, opcode_i (taken from the word being loaded) selects the next routine.
- R5: With opcode_i equal to the add opcode (6'h01 by default), the step after fetch asserts gpr_en_o and a_in_o, with gpr_in_o = 0 (register drives the bus) and gpr_idx_o = rs1_i.
- R6: The second add step asserts gpr_en_o and c_in_o, with gpr_in_o = 0, gpr_idx_o = rs2_i and alu_fn_o = 2'b01 (add).
- R7: The third add step asserts c_out_o and gpr_en_o, with gpr_in_o = 1 (register loads from the bus) and gpr_idx_o = rd_i. On the following cycle the first fetch step is active again.
- R8: Any other opcode at the end of fetch leads to a step in which only illegal_o is high. That state persists whatever mem_ready_i and opcode_i do, until reset.
- R9: c_in_o and c_out_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_ready_i | input | 1 | Memory has completed the requested read |
| opcode_i | input | 6 | Opcode field of the instruction word being fetched |
| rs1_i | input | 5 | First source register field |
| rs2_i | input | 5 | Second source register field |
| rd_i | input | 5 | Destination register field |
| pc_in_o | output | 1 | Load PC from bus |
| pc_out_o | output | 1 | Drive PC onto bus |
| pc_bout_o | output | 1 | Drive PC onto memory address path |
| ir_bin_o | output | 1 | Load IR from memory data path |
| a_in_o | output | 1 | Load A latch from bus |
| c_in_o | output | 1 | Load C latch from ALU |
| c_out_o | output | 1 | Drive C onto bus |
| mem_rd_o | output | 1 | Memory read request |
| alu_fn_o | output | 2 | ALU function: 00 none, 01 add, 10 add four |
| gpr_en_o | output | 1 | A general register takes part in this step |
| gpr_in_o | output | 1 | Direction: 1 load from bus, 0 drive bus |
| gpr_idx_o | output | 5 | Selected general register number |
| illegal_o | output | 1 | Halted on an opcode with no routine |

## Verification
A corrupted micro-program counter shows up at the ports in the same cycle, because every strobe is a direct decode of the current control-store word. A wrong address is therefore visible as a wrong strobe pattern at the very next sample. A fault in the stall logic appears one cycle after mem_ready_i is low: the step either advances early or fails to advance. A fault in dispatch or in the end marker shows one cycle after the third fetch step or the third add step, as the wrong routine's strobes or as a missing return to fetch. A fault in the vertical selector appears as a wrong register number in the step that uses it.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {ALU_NOP = 2'd0, ALU_ADD = 2'd1, ALU_ADD4 = 2'd2} alu_fn_e;
  typedef enum logic [1:0] {SEQ_NEXT = 2'd0, SEQ_DISP = 2'd1, SEQ_END = 2'd2, SEQ_HALT = 2'd3} seq_e;
  typedef enum logic [1:0] {SRC_RS1 = 2'd0, SRC_RS2 = 2'd1, SRC_RD = 2'd2} src_e;

  typedef struct packed {
    logic    pc_in;
    logic    pc_out;
    logic    pc_bout;
    logic    ir_bin;
    logic    a_in;
    logic    c_in;
    logic    c_out;
    logic    mem_rd;
    alu_fn_e alu;
    logic    gpr_en;
    logic    gpr_dir;   // 1: load from bus
    src_e    gpr_src;
    seq_e    seq;
    logic    illegal;
  } uword_t;

  localparam int unsigned UA_FETCH = 0;
  localparam int unsigned UA_ADD   = 3;
  localparam int unsigned UA_HALT  = 6;
  localparam int unsigned UA_MIN_DEPTH = 8;
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
#(
  parameter int unsigned UA_W = 3
) (
  input  logic [UA_W-1:0] addr_i,
  output uword_t          word_o
);
  function automatic uword_t blank();
    uword_t w;
    w = '0;
    w.alu = ALU_NOP;
    w.gpr_src = SRC_RS1;
    w.seq = SEQ_NEXT;
    return w;
  endfunction

  always_comb begin
    word_o = blank();
    case (int'(addr_i))
      UA_FETCH: begin
        word_o.pc_bout = 1'b1;
        word_o.mem_rd  = 1'b1;
        word_o.pc_out  = 1'b1;
        word_o.alu     = ALU_ADD4;
        word_o.c_in    = 1'b1;
      end
      UA_FETCH + 1: begin
        word_o.mem_rd = 1'b1;
        word_o.c_out  = 1'b1;
        word_o.pc_in  = 1'b1;
      end
      UA_FETCH + 2: begin
        word_o.mem_rd = 1'b1;
        word_o.ir_bin = 1'b1;
        word_o.seq    = SEQ_DISP;
      end
      UA_ADD: begin
        word_o.gpr_en  = 1'b1;
        word_o.gpr_src = SRC_RS1;
        word_o.a_in    = 1'b1;
      end
      UA_ADD + 1: begin
        word_o.gpr_en  = 1'b1;
        word_o.gpr_src = SRC_RS2;
        word_o.alu     = ALU_ADD;
        word_o.c_in    = 1'b1;
      end
      UA_ADD + 2: begin
        word_o.c_out   = 1'b1;
        word_o.gpr_en  = 1'b1;
        word_o.gpr_dir = 1'b1;
        word_o.gpr_src = SRC_RD;
        word_o.seq     = SEQ_END;
      end
      default: begin
        word_o.illegal = 1'b1;
        word_o.seq     = SEQ_HALT;
      end
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int unsigned UA_W  = 3,
  parameter int unsigned OPC_W = 6,
  parameter logic [OPC_W-1:0] OPC_ADD = 6'h01
) (
  input  logic [UA_W-1:0]  upc_i,
  input  seq_e             seq_i,
  input  logic             stall_i,
  input  logic [OPC_W-1:0] opcode_i,
  output logic [UA_W-1:0]  upc_o
);
  localparam logic [UA_W-1:0] A_FETCH = UA_W'(UA_FETCH);
  localparam logic [UA_W-1:0] A_ADD   = UA_W'(UA_ADD);
  localparam logic [UA_W-1:0] A_HALT  = UA_W'(UA_HALT);

  logic [UA_W-1:0] disp_addr;

  always_comb begin
    disp_addr = A_HALT;
    if (opcode_i == OPC_ADD) disp_addr = A_ADD;
  end

  always_comb begin
    if (stall_i) upc_o = upc_i;
    else begin
      case (seq_i)
        SEQ_DISP: upc_o = disp_addr;
        SEQ_END:  upc_o = A_FETCH;
        SEQ_HALT: upc_o = upc_i;
        default:  upc_o = upc_i + UA_W'(1);
      endcase
    end
  end
endmodule

// File: rtl/useq_regsel.sv
module useq_regsel
  import useq_pkg::*;
#(
  parameter int unsigned RIDX_W = 5
) (
  input  logic              en_i,
  input  src_e              src_i,
  input  logic [RIDX_W-1:0] rs1_i,
  input  logic [RIDX_W-1:0] rs2_i,
  input  logic [RIDX_W-1:0] rd_i,
  output logic [RIDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    if (en_i) begin
      case (src_i)
        SRC_RS1: idx_o = rs1_i;
        SRC_RS2: idx_o = rs2_i;
        SRC_RD:  idx_o = rd_i;
        default: idx_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int unsigned UCS_DEPTH = 8,
  parameter int unsigned OPC_W     = 6,
  parameter int unsigned RIDX_W    = 5,
  parameter logic [OPC_W-1:0] OPC_ADD = 6'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mem_ready_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [RIDX_W-1:0] rs1_i,
  input  logic [RIDX_W-1:0] rs2_i,
  input  logic [RIDX_W-1:0] rd_i,
  output logic              pc_in_o,
  output logic              pc_out_o,
  output logic              pc_bout_o,
  output logic              ir_bin_o,
  output logic              a_in_o,
  output logic              c_in_o,
  output logic              c_out_o,
  output logic              mem_rd_o,
  output logic [1:0]        alu_fn_o,
  output logic              gpr_en_o,
  output logic              gpr_in_o,
  output logic [RIDX_W-1:0] gpr_idx_o,
  output logic              illegal_o
);
  localparam int unsigned UA_W = (UCS_DEPTH < UA_MIN_DEPTH) ? $clog2(UA_MIN_DEPTH) : $clog2(UCS_DEPTH);

  logic [UA_W-1:0] upc_q, upc_d;
  uword_t          word;
  logic            stall;

  useq_rom #(.UA_W(UA_W)) u_rom (.addr_i(upc_q), .word_o(word));

  assign stall = word.mem_rd && !mem_ready_i;

  useq_next #(.UA_W(UA_W), .OPC_W(OPC_W), .OPC_ADD(OPC_ADD)) u_next (
    .upc_i   (upc_q),
    .seq_i   (word.seq),
    .stall_i (stall),
    .opcode_i(opcode_i),
    .upc_o   (upc_d)
  );

  useq_regsel #(.RIDX_W(RIDX_W)) u_sel (
    .en_i (word.gpr_en),
    .src_i(word.gpr_src),
    .rs1_i(rs1_i),
    .rs2_i(rs2_i),
    .rd_i (rd_i),
    .idx_o(gpr_idx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upc_q <= UA_W'(UA_FETCH);
    else         upc_q <= upc_d;
  end

  assign pc_in_o   = word.pc_in;
  assign pc_out_o  = word.pc_out;
  assign pc_bout_o = word.pc_bout;
  assign ir_bin_o  = word.ir_bin;
  assign a_in_o    = word.a_in;
  assign c_in_o    = word.c_in;
  assign c_out_o   = word.c_out;
  assign mem_rd_o  = word.mem_rd;
  assign alu_fn_o  = word.alu;
  assign gpr_en_o  = word.gpr_en;
  assign gpr_in_o  = word.gpr_dir;
  assign illegal_o = word.illegal;
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter int unsigned RIDX_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_ready_i,
  input logic              pc_in_o,
  input logic              pc_out_o,
  input logic              pc_bout_o,
  input logic              ir_bin_o,
  input logic              a_in_o,
  input logic              c_in_o,
  input logic              c_out_o,
  input logic              mem_rd_o,
  input logic [1:0]        alu_fn_o,
  input logic              gpr_en_o,
  input logic              gpr_in_o,
  input logic [RIDX_W-1:0] gpr_idx_o,
  input logic              illegal_o
);
  logic [12:0] ctl;
  assign ctl = {pc_in_o, pc_out_o, pc_bout_o, ir_bin_o, a_in_o, c_in_o, c_out_o,
                mem_rd_o, alu_fn_o, gpr_en_o, gpr_in_o, illegal_o};

  assert_stall_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o && !mem_ready_i) |=> $stable(ctl));

  assert_pc_load_after_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pc_in_o) |-> $past(c_in_o && alu_fn_o == 2'b10));

  assert_dispatch_add_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_bin_o && mem_ready_i) |=> (illegal_o || (a_in_o && gpr_en_o && !gpr_in_o)));

  assert_end_returns_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_out_o && gpr_en_o && gpr_in_o) |=> (pc_bout_o && mem_rd_o && alu_fn_o == 2'b10));

  assert_halt_sticks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> (illegal_o && !mem_rd_o && !gpr_en_o));

  assert_c_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(c_in_o && c_out_o));
endmodule

bind useq_ctrl useq_ctrl_chk #(.RIDX_W(RIDX_W)) u_chk (.*);

// File: tb/useq_ctrl_test.sv
module useq_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mem_ready_i = 1'b0;
  logic [5:0] opcode_i = '0;
  logic [4:0] rs1_i = '0, rs2_i = '0, rd_i = '0;
  logic pc_in_o, pc_out_o, pc_bout_o, ir_bin_o, a_in_o, c_in_o, c_out_o, mem_rd_o;
  logic [1:0] alu_fn_o;
  logic gpr_en_o, gpr_in_o, illegal_o;
  logic [4:0] gpr_idx_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // pc_in pc_out pc_bout ir_bin a_in c_in c_out mem_rd alu[1:0] gpr_en gpr_in illegal
  localparam logic [12:0] V_F1   = 13'b0110010110000;
  localparam logic [12:0] V_F2   = 13'b1000001100000;
  localparam logic [12:0] V_F3   = 13'b0001000100000;
  localparam logic [12:0] V_A1   = 13'b0000100000100;
  localparam logic [12:0] V_A2   = 13'b0000010001100;
  localparam logic [12:0] V_A3   = 13'b0000001000110;
  localparam logic [12:0] V_HALT = 13'b0000000000001;

  useq_ctrl uut (.*);

  always #10 clk_i = ~clk_i;

  function automatic logic [12:0] ctl();
    return {pc_in_o, pc_out_o, pc_bout_o, ir_bin_o, a_in_o, c_in_o, c_out_o,
            mem_rd_o, alu_fn_o, gpr_en_o, gpr_in_o, illegal_o};
  endfunction

  task automatic expect_ctl(input logic [12:0] exp, input logic [4:0] exp_idx, input string tag);
    checks++;
    if (ctl() !== exp || gpr_idx_o !== exp_idx) begin
      failures++;
      $display("FAIL %s: ctl=%b idx=%0d expected ctl=%b idx=%0d", tag, ctl(), gpr_idx_o, exp, exp_idx);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    mem_ready_i = 1'b0;
    tick();
    tick();
    rst_ni = 1'b1;
    tick();
    expect_ctl(V_F1, 5'd0, "R1 reset state");
  endtask

  // runs fetch from step 1 with given stall counts, ends sampled in first post-fetch step
  task automatic run_fetch(input int st1, input int st2, input int st3, input logic [5:0] opc);
    mem_ready_i = 1'b0;
    for (int i = 0; i < st1; i++) begin
      tick();
      expect_ctl(V_F1, 5'd0, "R2 stall in fetch step 1");
    end
    mem_ready_i = 1'b1;
    tick();
    expect_ctl(V_F2, 5'd0, "R3 fetch step 2");
    mem_ready_i = 1'b0;
    for (int i = 0; i < st2; i++) begin
      tick();
      expect_ctl(V_F2, 5'd0, "R2 stall in fetch step 2");
    end
    mem_ready_i = 1'b1;
    tick();
    expect_ctl(V_F3, 5'd0, "R4 fetch step 3");
    mem_ready_i = 1'b0;
    opcode_i = opc;
    for (int i = 0; i < st3; i++) begin
      tick();
      expect_ctl(V_F3, 5'd0, "R2 stall in fetch step 3");
    end
    mem_ready_i = 1'b1;
    tick();
    mem_ready_i = 1'b0;
    opcode_i = 6'h3f;
  endtask

  task automatic t_add(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d,
                       input int st1, input int st2, input int st3);
    rs1_i = a; rs2_i = b; rd_i = d;
    run_fetch(st1, st2, st3, 6'h01);
    expect_ctl(V_A1, a, "R5 add step 1 source-1 to A");
    tick();
    expect_ctl(V_A2, b, "R6 add step 2 source-2 add into C");
    tick();
    expect_ctl(V_A3, d, "R7 add step 3 C to destination");
    tick();
    expect_ctl(V_F1, 5'd0, "R7 return to fetch");
  endtask

  task automatic t_illegal(input logic [5:0] opc);
    run_fetch(0, 0, 0, opc);
    expect_ctl(V_HALT, 5'd0, "R8 illegal opcode halt");
    mem_ready_i = 1'b1;
    opcode_i = 6'h01;
    for (int i = 0; i < 4; i++) begin
      tick();
      expect_ctl(V_HALT, 5'd0, "R8 halt persists");
    end
    do_reset();
  endtask

  task automatic t_c_exclusive();
    checks++;
    if (c_in_o && c_out_o) begin
      failures++;
      $display("FAIL R9: c_in=%b c_out=%b expected not both", c_in_o, c_out_o);
    end
  endtask

  initial begin
    do_reset();
    t_add(5'd5, 5'd7, 5'd9, 2, 1, 1);
    t_c_exclusive();
    t_add(5'd31, 5'd0, 5'd17, 0, 0, 0);
    t_add(5'd12, 5'd12, 5'd1, 3, 0, 2);
    t_illegal(6'h00);
    t_illegal(6'h02);
    t_add(5'd3, 5'd30, 5'd31, 0, 1, 0);
    t_c_exclusive();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule